// File: doc/BRIEF.md
# ARINC 429 Serial Word Transmitter

This block turns 32-bit ARINC 429 words into return-to-zero pulses on a pair of rail outputs. One rail pulses for each zero bit and the other for each one bit; both rails low is the null level. Each bit lasts four cycles of the transmit clock, which therefore runs at four times the line bit rate. Bits go out least significant first, and consecutive words are separated by at least four null bit times.

A host sets a four-bit control register and fills the transmit buffer. In word mode the buffer takes the whole word in one write. In byte mode it takes four byte writes. The first byte can start the word, and the remaining three must arrive while the word is already on the line. A status register, read with a strobe, reports the ready, idle and underrun-error flags. Odd parity can replace bit 32. A clear-to-send style hold input gates the start of each word. A loopback mode steers the pulses to an internal pair of outputs and keeps the external rails at null.

A late byte in byte mode aborts the word and raises a pending error. While the error is pending the transmitter is blocked. A status read clears the error, and so does master reset.

Top module: `a429_word_tx`

## Requirements
- R1: While `masterRst` is high and in the cycle after it falls, `statusOut` reads 8'h05, `ready` and `lineIdle` are 1, `errFlag` is 0 and all four rail outputs are 0.
- R2: During a word, each bit takes exactly 4 clock cycles. In the first 2 cycles exactly one rail of the active pair is high: the one-rail for a 1 bit, the zero-rail for a 0 bit. In the last 2 cycles both rails are low. The two rails of a pair are never high together.
- R3: Bits are sent least significant first. In word mode (control bit 1 = 0), a write while `ready` is high loads all 32 bits of `dataIn`. `ready` then stays low until that word has been sent.
- R4: When control bit 2 is 1, bit 32 (sent last) carries odd parity over the whole word and replaces the stored bit 31.
- R5: `lineIdle` and status bit 2 are 0 for exactly the 128 cycles of a word and 1 otherwise.
- R6: Between the last cycle of one word and the first cycle of the next, at least 16 cycles have both rails low.
- R7: No word starts while control bit 0 is 0. Setting it to 1 when the buffer is loaded starts the word.
- R8: While `sendHold` is 1 no new word starts. Taking it to 0 releases a loaded word.
- R9: When control bit 3 is 1, the pulses appear on `loopOne`/`loopZero` and `railOne`/`railZero` stay 0. When it is 0, the loop outputs stay 0.
- R10: In byte mode (control bit 1 = 1), byte writes use `dataIn[7:0]`. The first byte fills word bits 1 to 8, and later bytes fill the following bit groups in order. One loaded byte is enough to start a word. `ready` and status bit 0 stay high while fewer than four bytes are held.
- R11: In byte mode, the word is aborted when the last cycle of the eighth bit of byte k (k = 1..3) ends before byte k+1 has been written. In that case `errFlag` and status bit 7 go to 1, and the rails return to null.
- R12: While an error is pending, `ready` is 0, buffer writes are ignored and no word starts. A cycle with `rdStatus` high returns the status with bit 7 set and clears the error at the next clock edge.
- R13: Master reset clears a pending error and sets the control register to 4'b0011: transmitter enabled, byte mode, no parity, no loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, four cycles per line bit |
| masterRst | input | 1 | Synchronous master reset, active high |
| wrCtrl | input | 1 | Control register write strobe |
| ctrlIn | input | 4 | Control value: bit0 enable, bit1 byte mode, bit2 parity, bit3 loopback |
| wrData | input | 1 | Transmit buffer write strobe |
| dataIn | input | 32 | Buffer write data (bits 7:0 only in byte mode) |
| rdStatus | input | 1 | Status read strobe; clears a pending error |
| statusOut | output | 8 | Status: bit0 ready, bit2 idle, bit7 underrun error |
| sendHold | input | 1 | High holds off the start of the next word |
| ready | output | 1 | Buffer may be written |
| lineIdle | output | 1 | Low while a word is being sent |
| errFlag | output | 1 | Underrun error pending |
| railZero | output | 1 | External rail pulsed for a 0 bit |
| railOne | output | 1 | External rail pulsed for a 1 bit |
| loopZero | output | 1 | Internal loopback rail for a 0 bit |
| loopOne | output | 1 | Internal loopback rail for a 1 bit |

## Verification
The assertions assume that the host changes neither the byte-mode nor the parity bit while a word is on the line. They also assume that the host does not write a byte in the very cycle in which the sequencer checks that byte's deadline. The bench changes mode only when the line is idle and the gap has elapsed, and it writes stream bytes only a few cycles after a word starts, far from any deadline edge. The hold input is treated as an ordinary level that may change at any cycle, and the bench moves it only on falling clock edges.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int WORD_BITS      = 32;
  localparam int BYTE_BITS      = 8;
  localparam int BYTES_PER_WORD = WORD_BITS / BYTE_BITS;
  localparam int CLKS_PER_BIT   = 4;   // power of two
  localparam int GAP_BITS       = 4;
  localparam int GAP_CLKS       = GAP_BITS * CLKS_PER_BIT;
  localparam int WORD_CLKS      = WORD_BITS * CLKS_PER_BIT;
  localparam int BIT_IDX_W      = $clog2(WORD_BITS);
  localparam int BYTE_IDX_W     = $clog2(BYTE_BITS);
  localparam int BYTE_SEL_W     = $clog2(BYTES_PER_WORD);
  localparam int PHASE_W        = $clog2(CLKS_PER_BIT);
  localparam int LOAD_W         = $clog2(BYTES_PER_WORD + 1);
  localparam int GAP_W          = $clog2(GAP_CLKS + 1);
  localparam int RUN_W          = $clog2(WORD_CLKS + 1);
  localparam int CTRL_W         = 4;
  localparam int STAT_W         = 8;

  localparam int CTL_EN   = 0;
  localparam int CTL_BYTE = 1;
  localparam int CTL_PAR  = 2;
  localparam int CTL_LOOP = 3;
  localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 4'b0011;

  typedef struct packed {
    logic                  loadWord;
    logic                  loadByte;
    logic [BYTE_SEL_W-1:0] byteSel;
    logic                  active;
    logic [BIT_IDX_W-1:0]  bitIdx;
    logic                  pulseHalf;
    logic                  parityEn;
    logic                  loopback;
  } dpStrobe_t;
endpackage

// File: rtl/a429_tx_dpath.sv
module a429_tx_dpath
  import a429_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 masterRst,
  input  dpStrobe_t            st,
  input  logic [WORD_BITS-1:0] dataIn,
  output logic                 railZero,
  output logic                 railOne,
  output logic                 loopZero,
  output logic                 loopOne
);
  logic [WORD_BITS-1:0] wordBuf;
  logic parityBit, curBit, drive;

  // Byte lanes: a full-word load fills all lanes, a byte load fills one.
  always_ff @(posedge clk) begin
    if (masterRst) begin
      wordBuf <= '0;
    end else begin
      for (int lane = 0; lane < BYTES_PER_WORD; lane++) begin
        if (st.loadWord)
          wordBuf[lane*BYTE_BITS +: BYTE_BITS] <= dataIn[lane*BYTE_BITS +: BYTE_BITS];
        else if (st.loadByte && st.byteSel == BYTE_SEL_W'(lane))
          wordBuf[lane*BYTE_BITS +: BYTE_BITS] <= dataIn[BYTE_BITS-1:0];
      end
    end
  end

  // Odd parity over the first WORD_BITS-1 bits fills the last position.
  assign parityBit = ~^wordBuf[WORD_BITS-2:0];
  assign curBit = (st.parityEn && st.bitIdx == BIT_IDX_W'(WORD_BITS-1))
                  ? parityBit : wordBuf[st.bitIdx];
  assign drive  = st.active && st.pulseHalf;

  assign railOne  = drive && !st.loopback &&  curBit;
  assign railZero = drive && !st.loopback && !curBit;
  assign loopOne  = drive &&  st.loopback &&  curBit;
  assign loopZero = drive &&  st.loopback && !curBit;

  // R2: a rail pair never carries both levels at once
  a_r2_pair_exclusive: assert property (@(posedge clk) disable iff (masterRst)
    !(railZero && railOne) && !(loopZero && loopOne));

  // R2: second half of every bit cell is null on all rails
  a_r2_null_half: assert property (@(posedge clk) disable iff (masterRst)
    !st.pulseHalf |-> !(railZero || railOne || loopZero || loopOne));

  // R9: loopback keeps the external rails quiet
  a_r9_loop_quiet: assert property (@(posedge clk) disable iff (masterRst)
    st.loopback |-> !(railZero || railOne));
endmodule

// File: rtl/a429_tx_ctrl.sv
module a429_tx_ctrl
  import a429_tx_pkg::*;
(
  input  logic              clk,
  input  logic              masterRst,
  input  logic              wrCtrl,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  logic              wrData,
  input  logic              rdStatus,
  input  logic              sendHold,
  output dpStrobe_t         st,
  output logic              ready,
  output logic              lineIdle,
  output logic              errFlag,
  output logic [STAT_W-1:0] statusOut
);
  logic [CTRL_W-1:0]    ctrlReg;
  logic                 errPend;
  logic [LOAD_W-1:0]    loadCnt;
  logic                 active;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [PHASE_W-1:0]   phase;
  logic [GAP_W-1:0]     gapCnt;

  logic enable, byteMode, lastPhase, byteEnd, lastByte;
  logic underrun, wordEnd, wrAccept, bufReady, canStart;
  logic [BYTE_SEL_W-1:0] byteNum;

  assign enable    = ctrlReg[CTL_EN];
  assign byteMode  = ctrlReg[CTL_BYTE];
  assign lastPhase = phase == PHASE_W'(CLKS_PER_BIT - 1);
  assign byteEnd   = bitIdx[BYTE_IDX_W-1:0] == {BYTE_IDX_W{1'b1}};
  assign byteNum   = bitIdx[BIT_IDX_W-1:BYTE_IDX_W];
  assign lastByte  = byteNum == BYTE_SEL_W'(BYTES_PER_WORD - 1);

  // The byte after the current one must be held by the end of its eighth bit.
  assign underrun  = active && lastPhase && byteMode && byteEnd && !lastByte &&
                     (LOAD_W'(byteNum) + LOAD_W'(2) > loadCnt);
  assign wordEnd   = active && lastPhase && bitIdx == BIT_IDX_W'(WORD_BITS - 1);

  assign bufReady  = byteMode ? (loadCnt < LOAD_W'(BYTES_PER_WORD))
                              : (loadCnt == '0);
  assign ready     = !errPend && bufReady;
  assign wrAccept  = wrData && ready;

  assign canStart  = !active && gapCnt == '0 && !errPend && enable && !sendHold &&
                     (byteMode ? (loadCnt != '0)
                               : (loadCnt == LOAD_W'(BYTES_PER_WORD)));

  always_ff @(posedge clk) begin
    if (masterRst) begin
      ctrlReg <= CTRL_DEFAULT;
      errPend <= 1'b0;
      loadCnt <= '0;
      active  <= 1'b0;
      bitIdx  <= '0;
      phase   <= '0;
      gapCnt  <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= ctrlIn;

      if (underrun)      errPend <= 1'b1;
      else if (rdStatus) errPend <= 1'b0;

      if (underrun || wordEnd) loadCnt <= '0;
      else if (wrAccept)       loadCnt <= byteMode ? loadCnt + LOAD_W'(1)
                                                   : LOAD_W'(BYTES_PER_WORD);

      if (underrun || wordEnd) gapCnt <= GAP_W'(GAP_CLKS);
      else if (gapCnt != '0)   gapCnt <= gapCnt - GAP_W'(1);

      if (canStart) begin
        active <= 1'b1;
        bitIdx <= '0;
        phase  <= '0;
      end else if (active) begin
        if (underrun || wordEnd) begin
          active <= 1'b0;
          bitIdx <= '0;
          phase  <= '0;
        end else begin
          phase <= lastPhase ? '0 : phase + PHASE_W'(1);
          if (lastPhase) bitIdx <= bitIdx + BIT_IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    st           = '0;
    st.loadWord  = wrAccept && !byteMode;
    st.loadByte  = wrAccept && byteMode;
    st.byteSel   = loadCnt[BYTE_SEL_W-1:0];
    st.active    = active;
    st.bitIdx    = bitIdx;
    st.pulseHalf = phase < PHASE_W'(CLKS_PER_BIT / 2);
    st.parityEn  = ctrlReg[CTL_PAR];
    st.loopback  = ctrlReg[CTL_LOOP];
  end

  assign lineIdle  = !active;
  assign errFlag   = errPend;
  assign statusOut = {errPend, 4'b0000, !active, 1'b0, ready};

  // Checker state: cycles since word start, idle cycles since last word.
  logic [RUN_W-1:0] runCnt;
  logic [GAP_W-1:0] idleCnt;
  always_ff @(posedge clk) begin
    if (masterRst) begin
      runCnt  <= '0;
      idleCnt <= GAP_W'(GAP_CLKS);
    end else begin
      if (canStart)    runCnt <= '0;
      else if (active) runCnt <= runCnt + RUN_W'(1);
      if (active)                              idleCnt <= '0;
      else if (idleCnt < GAP_W'(GAP_CLKS))     idleCnt <= idleCnt + GAP_W'(1);
    end
  end

  // R5: a completed word occupies exactly WORD_CLKS cycles
  a_r5_word_length: assert property (@(posedge clk) disable iff (masterRst)
    wordEnd |-> runCnt == RUN_W'(WORD_CLKS - 1));

  // R6: a word starts only after a full null gap
  a_r6_min_gap: assert property (@(posedge clk) disable iff (masterRst)
    $rose(active) |-> $past(idleCnt) >= GAP_W'(GAP_CLKS));

  // R7: disabled transmitter stays idle
  a_r7_enable_gate: assert property (@(posedge clk) disable iff (masterRst)
    !enable && !active |=> !active);

  // R8: hold input keeps an idle line idle
  a_r8_hold_gate: assert property (@(posedge clk) disable iff (masterRst)
    sendHold && !active |=> !active);

  // R11: raising the error ends the word on the same edge
  a_r11_abort: assert property (@(posedge clk) disable iff (masterRst)
    $rose(errPend) |-> !active);

  // R12: a pending error blocks any start
  a_r12_err_blocks: assert property (@(posedge clk) disable iff (masterRst)
    errPend && !active |=> !active);
endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx
  import a429_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 masterRst,
  input  logic                 wrCtrl,
  input  logic [CTRL_W-1:0]    ctrlIn,
  input  logic                 wrData,
  input  logic [WORD_BITS-1:0] dataIn,
  input  logic                 rdStatus,
  output logic [STAT_W-1:0]    statusOut,
  input  logic                 sendHold,
  output logic                 ready,
  output logic                 lineIdle,
  output logic                 errFlag,
  output logic                 railZero,
  output logic                 railOne,
  output logic                 loopZero,
  output logic                 loopOne
);
  dpStrobe_t st;

  a429_tx_ctrl uCtrl (
    .clk(clk), .masterRst(masterRst), .wrCtrl(wrCtrl), .ctrlIn(ctrlIn),
    .wrData(wrData), .rdStatus(rdStatus), .sendHold(sendHold), .st(st),
    .ready(ready), .lineIdle(lineIdle), .errFlag(errFlag), .statusOut(statusOut)
  );

  a429_tx_dpath uDpath (
    .clk(clk), .masterRst(masterRst), .st(st), .dataIn(dataIn),
    .railZero(railZero), .railOne(railOne), .loopZero(loopZero), .loopOne(loopOne)
  );
endmodule

// File: tb/tb_a429_word_tx.sv
module tb_a429_word_tx;
  logic        clk = 1'b0;
  logic        masterRst = 1'b1;
  logic        wrCtrl = 1'b0;
  logic [3:0]  ctrlIn = '0;
  logic        wrData = 1'b0;
  logic [31:0] dataIn = '0;
  logic        rdStatus = 1'b0;
  logic [7:0]  statusOut;
  logic        sendHold = 1'b0;
  logic        ready, lineIdle, errFlag, railZero, railOne, loopZero, loopOne;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  a429_word_tx dut (
    .clk(clk), .masterRst(masterRst), .wrCtrl(wrCtrl), .ctrlIn(ctrlIn),
    .wrData(wrData), .dataIn(dataIn), .rdStatus(rdStatus), .statusOut(statusOut),
    .sendHold(sendHold), .ready(ready), .lineIdle(lineIdle), .errFlag(errFlag),
    .railZero(railZero), .railOne(railOne), .loopZero(loopZero), .loopOne(loopOne)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All host tasks start and end on a falling edge.
  task automatic writeCtrl(input logic [3:0] v);
    wrCtrl = 1'b1; ctrlIn = v;
    @(negedge clk);
    wrCtrl = 1'b0;
  endtask

  task automatic writeWord(input logic [31:0] v);
    wrData = 1'b1; dataIn = v;
    @(negedge clk);
    wrData = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] v);
    wrData = 1'b1; dataIn = {24'h0, v};
    @(negedge clk);
    wrData = 1'b0;
  endtask

  task automatic readStatus(output logic [7:0] s);
    rdStatus = 1'b1;
    s = statusOut;
    @(negedge clk);
    rdStatus = 1'b0;
  endtask

  task automatic idleWait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseReset();
    masterRst = 1'b1;
    idleWait(3);
    masterRst = 1'b0;
  endtask

  // Waits for a word to start, then checks bit cells, data and busy window.
  task automatic captureWord(input bit useLoop, input string tag, input logic [31:0] exp);
    int n = 0;
    int bad = 0;
    int extHigh = 0;
    int busyBad = 0;
    logic [31:0] got = '0;
    logic hi, lo;
    while (lineIdle === 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(lineIdle === 1'b0, {tag, " word start"}, 32'(n), 32'd0);
    if (lineIdle !== 1'b0) return;
    for (int b = 0; b < 32; b++) begin
      for (int p = 0; p < 4; p++) begin
        hi = useLoop ? loopOne : railOne;
        lo = useLoop ? loopZero : railZero;
        if (useLoop && (railOne || railZero)) extHigh++;
        if (!useLoop && (loopOne || loopZero)) extHigh++;
        if (lineIdle !== 1'b0) busyBad++;
        if (p < 2) begin
          if ((hi ^ lo) !== 1'b1) bad++;
          if (p == 0) got[b] = hi;
        end else if (hi || lo) begin
          bad++;
        end
        @(negedge clk);
      end
    end
    check(bad == 0, "R2 bit cell shape", 32'(bad), 32'd0);
    check(got === exp, {tag, " data"}, got, exp);
    check(busyBad == 0 && lineIdle === 1'b1, "R5 busy window 128 cycles", 32'(busyBad), 32'd0);
    check(extHigh == 0, "R9 unused rail pair quiet", 32'(extHigh), 32'd0);
  endtask

  task automatic testResetDefault();
    logic [7:0] s;
    check(statusOut === 8'h05 && ready && lineIdle && !errFlag, "R1 status after reset",
          {24'h0, statusOut}, 32'h05);
    check(!(railZero || railOne || loopZero || loopOne), "R1 rails after reset",
          {28'h0, railZero, railOne, loopZero, loopOne}, 32'h0);
    writeByte(8'h5A);
    check(ready === 1'b1, "R13 default is byte mode", {31'h0, ready}, 32'h1);
    idleWait(2);
    check(lineIdle === 1'b0, "R13 default is enabled", {31'h0, lineIdle}, 32'h0);
    idleWait(60);
    check(errFlag === 1'b1 && lineIdle === 1'b1, "R11 underrun after first byte",
          {30'h0, errFlag, lineIdle}, 32'h3);
    readStatus(s);
    check(s === 8'h84, "R12 status shows error", {24'h0, s}, 32'h84);
    check(!errFlag && statusOut === 8'h05, "R12 read clears error", {24'h0, statusOut}, 32'h05);
    idleWait(20);
  endtask

  task automatic testWordMode();
    writeCtrl(4'b0001);
    writeWord(32'hA5C3_0F96);
    check(ready === 1'b0 && statusOut[0] === 1'b0, "R3 ready low once loaded", {31'h0, ready}, 32'h0);
    captureWord(1'b0, "R3 word LSB first", 32'hA5C3_0F96);
    check(ready === 1'b1, "R3 ready back after word", {31'h0, ready}, 32'h1);
  endtask

  task automatic testParity();
    writeCtrl(4'b0101);
    idleWait(20);
    writeWord(32'h0000_0001);
    captureWord(1'b0, "R4 parity already odd", 32'h0000_0001);
    writeWord(32'h0000_0003);
    captureWord(1'b0, "R4 parity bit set", 32'h8000_0003);
    writeWord(32'h8000_0001);
    captureWord(1'b0, "R4 stored bit 32 replaced", 32'h0000_0001);
  endtask

  task automatic testGap();
    int gap = 1;
    writeCtrl(4'b0001);
    idleWait(20);
    writeWord(32'h1234_5678);
    captureWord(1'b0, "R6 first word", 32'h1234_5678);
    writeWord(32'h8765_4321);
    while (lineIdle === 1'b1 && gap < 200) begin
      if (railOne || railZero) gap = 1000;
      gap++;
      @(negedge clk);
    end
    check(gap >= 16 && gap < 200, "R6 null gap between words", 32'(gap), 32'd16);
    captureWord(1'b0, "R6 second word", 32'h8765_4321);
  endtask

  task automatic testEnable();
    writeCtrl(4'b0000);
    idleWait(20);
    writeWord(32'hDEAD_BEEF);
    idleWait(30);
    check(lineIdle === 1'b1 && ready === 1'b0, "R7 disabled holds word", {30'h0, lineIdle, ready}, 32'h2);
    writeCtrl(4'b0001);
    captureWord(1'b0, "R7 enable releases word", 32'hDEAD_BEEF);
  endtask

  task automatic testHold();
    sendHold = 1'b1;
    idleWait(20);
    writeWord(32'h0F0F_3C3C);
    idleWait(30);
    check(lineIdle === 1'b1, "R8 hold keeps line idle", {31'h0, lineIdle}, 32'h1);
    sendHold = 1'b0;
    captureWord(1'b0, "R8 release sends word", 32'h0F0F_3C3C);
  endtask

  task automatic testLoopback();
    writeCtrl(4'b1001);
    idleWait(20);
    writeWord(32'h6B2D_91E4);
    captureWord(1'b1, "R9 loopback word", 32'h6B2D_91E4);
    writeCtrl(4'b0001);
  endtask

  task automatic testBytes();
    sendHold = 1'b1;
    writeCtrl(4'b0011);
    idleWait(20);
    writeByte(8'h11); writeByte(8'h22); writeByte(8'h33);
    check(ready === 1'b1 && statusOut[0] === 1'b1, "R10 ready with three bytes", {31'h0, ready}, 32'h1);
    writeByte(8'h44);
    check(ready === 1'b0, "R10 ready low with four bytes", {31'h0, ready}, 32'h0);
    sendHold = 1'b0;
    captureWord(1'b0, "R10 preloaded bytes", 32'h4433_2211);
    idleWait(20);
    writeByte(8'hC4);
    fork
      captureWord(1'b0, "R10 bytes loaded in flight", 32'h7E01_B3C4);
      begin
        idleWait(3);
        check(ready === 1'b1, "R10 ready during word", {31'h0, ready}, 32'h1);
        writeByte(8'hB3); writeByte(8'h01); writeByte(8'h7E);
        check(ready === 1'b0, "R10 ready low when full", {31'h0, ready}, 32'h0);
      end
    join
  endtask

  task automatic testUnderrun();
    logic [7:0] s;
    idleWait(20);
    writeByte(8'hAA);
    idleWait(4);
    writeByte(8'h55);
    idleWait(120);
    check(errFlag === 1'b1 && statusOut === 8'h84, "R11 underrun on third byte",
          {24'h0, statusOut}, 32'h84);
    check(!(railOne || railZero) && lineIdle, "R11 rails null after abort",
          {30'h0, railOne, railZero}, 32'h0);
    writeByte(8'hEE);
    idleWait(30);
    check(lineIdle === 1'b1 && ready === 1'b0, "R12 no start while error", {30'h0, lineIdle, ready}, 32'h2);
    readStatus(s);
    check(s[7] === 1'b1 && errFlag === 1'b0, "R12 read clears error", {24'h0, s}, 32'h84);
    sendHold = 1'b1;
    idleWait(20);
    writeByte(8'h01); writeByte(8'h02); writeByte(8'h03); writeByte(8'h04);
    sendHold = 1'b0;
    captureWord(1'b0, "R12 ignored write left no byte", 32'h0403_0201);
  endtask

  task automatic testMasterReset();
    idleWait(20);
    writeByte(8'h3C);
    idleWait(60);
    check(errFlag === 1'b1, "R13 error raised before reset", {31'h0, errFlag}, 32'h1);
    writeCtrl(4'b1100);
    pulseReset();
    check(!errFlag && statusOut === 8'h05, "R13 reset clears error", {24'h0, statusOut}, 32'h05);
    writeByte(8'h80);
    check(ready === 1'b1, "R13 reset restores byte mode", {31'h0, ready}, 32'h1);
    idleWait(1);
    check(lineIdle === 1'b0 && railZero === 1'b1 && !railOne && !loopZero && !loopOne,
          "R13 reset restores enable and external rails",
          {28'h0, railZero, railOne, loopZero, loopOne}, 32'h8);
    idleWait(60);
    pulseReset();
  endtask

  initial begin
    idleWait(5);
    masterRst = 1'b0;
    check(statusOut === 8'h05, "R1 first cycle after reset", {24'h0, statusOut}, 32'h05);
    testResetDefault();
    testWordMode();
    testParity();
    testGap();
    testEnable();
    testHold();
    testLoopback();
    testBytes();
    testUnderrun();
    testMasterReset();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule